// File: doc/BRIEF.md
# Byte-Staged Indirect Control Register Interface

This block is the host-facing configuration port of a larger datapath. A host with an 8-bit data bus, a 3-bit address, an active-low chip enable, a write strobe and an active-low read enable assembles a 32-bit value one byte at a time in a staging register. It then names one of up to 32 internal control words by writing an index to a dedicated bus address. That index write copies the whole staging value into the named word. The control words live in the core clock domain and are presented in parallel to the rest of the chip.

Writes are captured on the rising edge of the write strobe. The commit request is carried into the core clock domain as a toggle that passes through a two-flop synchronizer and an edge detector. The host must leave at least four core clock cycles between a commit and the next staging write, and must keep the strobe rate at or below a quarter of the core clock. Readback needs no clock. The index last written selects a word, and with read enable low the address lines steer one of its bytes onto the bus as a plain combinational multiplexer. The bus tristate is modelled by an output-enable pin. This is a plain register port with no stream traffic, so it carries no valid/ready handshake and no back-pressure.

Top module: `icr_top`

## Requirements
- R1: After reset every control word is zero, `bus_oe` is 0 and `bus_dout` is 0x00.
- R2: A processed write to bus address 0, 1, 2 or 3 loads staging bits 7:0, 15:8, 23:16 or 31:24 respectively, and leaves the other three bytes unchanged.
- R3: A processed write to bus address 4 with data bit 7 = 0 copies the staging register into the control word whose index is data bits 6:0. The copy is visible on `ctrl_words` (word k at bits 32k+31:32k) by the third rising core clock edge after the strobe edge.
- R4: A processed write to bus address 4 with data bit 7 = 1 only sets the readback index to data bits 6:0, and no control word changes.
- R5: A strobe edge is ignored when `cs_n` is 1 or `rd_n` is 0 at that edge. Neither the staging register nor the index changes.
- R6: `bus_oe` is 1 exactly when `cs_n` = 0 and `rd_n` = 0. While it is 0, `bus_dout` is 0x00.
- R7: With `bus_oe` = 1, addresses 0 to 3 place bytes 7:0, 15:8, 23:16 and 31:24 of the indexed word on `bus_dout` combinationally. Addresses 4 to 7 read 0x00.
- R8: The staging register keeps its value after a commit, so a later commit of the same staging value to another index produces an identical word.
- R9: A commit changes only the named word. An index of 32 or more commits nothing and reads back 0x00. A word never written reads zero.
- R10: A staging write issued four core cycles after a commit does not disturb the value that commit delivers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_strobe | input | 1 | Host write strobe; writes are captured on its rising edge |
| cs_n | input | 1 | Active-low chip enable |
| rd_n | input | 1 | Active-low read enable; 1 during writes |
| bus_addr | input | 3 | Byte lane (0-3) or index register (4) |
| bus_din | input | 8 | Host write data |
| bus_dout | output | 8 | Readback data |
| bus_oe | output | 1 | Drive enable for the external data pins |
| ctrl_words | output | 1024 | All control words, word k at bits 32k+31:32k |

## Verification
Two events can land in the same core cycle: a commit reaching the core domain, and the next staging write that the host is allowed to issue after the minimum gap. The bench commits one value and then overwrites the staging byte after exactly four core cycles, with strobe edges placed at a fixed offset from the core clock. It judges the committed word against the value staged before the overwrite. It also samples that word 1 ns after the commit strobe, where it must still hold its old contents, and samples it again after the synchronizer has settled.

// File: rtl/icr_pkg.sv
package icr_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = 7;
  localparam logic [ADDR_W-1:0] INDEX_ADDR = 3'd4;
  localparam int NO_COMMIT_BIT = 7;
  typedef logic [BYTE_W-1:0] bus_byte_t;
endpackage

// File: rtl/icr_stage.sv
module icr_stage
  import icr_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                wr_strobe,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                rd_n,
  input  logic [ADDR_W-1:0]   addr,
  input  bus_byte_t           din,
  output logic [WORD_W-1:0]   stage_word,
  output logic [SEL_W-1:0]    sel_idx,
  output logic                commit_tgl
);
  localparam int LANES = WORD_W / BYTE_W;

  logic accept;
  assign accept = !cs_n && rd_n;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge wr_strobe or negedge rst_n) begin
      if (!rst_n)
        stage_word[g*BYTE_W +: BYTE_W] <= '0;
      else if (accept && addr == ADDR_W'(g))
        stage_word[g*BYTE_W +: BYTE_W] <= din;
    end
  end

  always_ff @(posedge wr_strobe or negedge rst_n) begin
    if (!rst_n) begin
      sel_idx    <= '0;
      commit_tgl <= 1'b0;
    end else if (accept && addr == INDEX_ADDR) begin
      sel_idx <= din[SEL_W-1:0];
      if (!din[NO_COMMIT_BIT])
        commit_tgl <= ~commit_tgl;
    end
  end

  // R2
  lane0_load_chk: assert property (@(posedge wr_strobe) disable iff (!rst_n)
    (accept && addr == '0) |=> stage_word[BYTE_W-1:0] == $past(din));

  // R5
  ignored_write_chk: assert property (@(posedge wr_strobe) disable iff (!rst_n)
    !accept |=> ($stable(stage_word) && $stable(sel_idx) && $stable(commit_tgl)));
endmodule

// File: rtl/icr_sync.sv
module icr_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic commit_pulse
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= tgl_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign commit_pulse = sync_q ^ prev_q;

  // R3
  pulse_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> !commit_pulse);
endmodule

// File: rtl/icr_regfile.sv
module icr_regfile
  import icr_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit,
  input  logic [SEL_W-1:0]              idx,
  input  logic [WORD_W-1:0]             wdata,
  output logic [NUM_WORDS*WORD_W-1:0]   words_flat
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words_flat[g*WORD_W +: WORD_W] <= '0;
      else if (commit && 32'(idx) == g)
        words_flat[g*WORD_W +: WORD_W] <= wdata;
    end
  end

  function automatic logic [WORD_W-1:0] pick(input logic [NUM_WORDS*WORD_W-1:0] f,
                                             input logic [SEL_W-1:0] s);
    pick = '0;
    for (int k = 0; k < NUM_WORDS; k++)
      if (32'(s) == k) pick = f[k*WORD_W +: WORD_W];
  endfunction

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(words_flat));

  // R3
  commit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && 32'(idx) < NUM_WORDS) |=> pick(words_flat, $past(idx)) == $past(wdata));
endmodule

// File: rtl/icr_rdmux.sv
module icr_rdmux
  import icr_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 32
) (
  input  logic                          cs_n,
  input  logic                          rd_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [SEL_W-1:0]              sel_idx,
  input  logic [NUM_WORDS*WORD_W-1:0]   words_flat,
  output bus_byte_t                     dout,
  output logic                          oe
);
  localparam int LANES = WORD_W / BYTE_W;

  logic [WORD_W-1:0] word_sel;
  bus_byte_t         lane_sel;

  always_comb begin
    word_sel = '0;
    for (int k = 0; k < NUM_WORDS; k++)
      if (32'(sel_idx) == k) word_sel = words_flat[k*WORD_W +: WORD_W];
  end

  always_comb begin
    lane_sel = '0;
    for (int k = 0; k < LANES; k++)
      if (32'(addr) == k) lane_sel = word_sel[k*BYTE_W +: BYTE_W];
  end

  assign oe   = !cs_n && !rd_n;
  assign dout = oe ? lane_sel : '0;
endmodule

// File: rtl/icr_top.sv
module icr_top
  import icr_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_strobe,
  input  logic                          cs_n,
  input  logic                          rd_n,
  input  logic [2:0]                    bus_addr,
  input  logic [7:0]                    bus_din,
  output logic [7:0]                    bus_dout,
  output logic                          bus_oe,
  output logic [NUM_WORDS*WORD_W-1:0]   ctrl_words
);
  logic [WORD_W-1:0] stage_word;
  logic [SEL_W-1:0]  sel_idx;
  logic              commit_tgl;
  logic              commit_pulse;

  icr_stage #(.WORD_W(WORD_W)) u_stage (
    .wr_strobe  (wr_strobe),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .addr       (bus_addr),
    .din        (bus_din),
    .stage_word (stage_word),
    .sel_idx    (sel_idx),
    .commit_tgl (commit_tgl)
  );

  icr_sync u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .tgl_in       (commit_tgl),
    .commit_pulse (commit_pulse)
  );

  icr_regfile #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit_pulse),
    .idx        (sel_idx),
    .wdata      (stage_word),
    .words_flat (ctrl_words)
  );

  icr_rdmux #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_rdmux (
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .addr       (bus_addr),
    .sel_idx    (sel_idx),
    .words_flat (ctrl_words),
    .dout       (bus_dout),
    .oe         (bus_oe)
  );
endmodule

// File: tb/icr_top_test.sv
module icr_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_strobe = 1'b0;
  logic cs_n = 1'b1;
  logic rd_n = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic bus_oe;
  logic [1023:0] ctrl_words;

  icr_top uut (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .cs_n(cs_n), .rd_n(rd_n),
    .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .ctrl_words(ctrl_words)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          kind;   // 0: bus_dout, 1: control word, 2: bus_oe
    int          idx;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event sample_ev;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_stage = '0;
  logic [31:0] m_words [32];

  initial begin
    forever begin
      @(sample_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = {24'h0, bus_dout};
          1: act = ctrl_words[it.idx*32 +: 32];
          default: act = {31'h0, bus_oe};
        endcase
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(input int kind, input int idx, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic fire();
    -> sample_ev;
    #1;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d,
                           input logic ce_n, input logic re_n, input int half);
    cs_n = ce_n; rd_n = re_n; bus_addr = a; bus_din = d;
    #5 wr_strobe = 1'b1;
    if (!ce_n && re_n) begin
      if (a < 3'd4) m_stage[a*8 +: 8] = d;
      else if (a == 3'd4 && !d[7] && d[6:0] < 7'd32) m_words[d[4:0]] = m_stage;
    end
    #(half) wr_strobe = 1'b0;
    #(half - 5);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_write(a, d, 1'b0, 1'b1, 80);
  endtask

  task automatic check_words(input string tag);
    for (int k = 0; k < 32; k++) expect_item(1, k, m_words[k], tag);
    fire();
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
    cs_n = 1'b0; rd_n = 1'b0; bus_addr = a;
    #5;
    expect_item(0, 0, {24'h0, exp}, tag);
    expect_item(2, 0, 32'h1, tag);
    fire();
    cs_n = 1'b1; rd_n = 1'b1;
    #4;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    for (int k = 0; k < 32; k++) m_words[k] = '0;
    #35;
    // R1 reset state
    expect_item(0, 0, 32'h0, "R1 dout");
    expect_item(2, 0, 32'h0, "R1 oe");
    fire();
    check_words("R1 words");
    #64 rst_n = 1'b1;
    @(negedge clk);

    // R2 R3: stage four lanes, commit to word 12
    wr(3'd0, 8'hDD); wr(3'd1, 8'hCC); wr(3'd2, 8'hBB); wr(3'd3, 8'hAA);
    wr(3'd4, 8'h0C);
    check_words("R3 commit word 12");
    expect_item(1, 12, 32'hAABBCCDD, "R2 lane order");
    fire();

    // R7 readback lanes, upper addresses read zero
    bus_read(3'd0, 8'hDD, "R7 lane0");
    bus_read(3'd1, 8'hCC, "R7 lane1");
    bus_read(3'd2, 8'hBB, "R7 lane2");
    bus_read(3'd3, 8'hAA, "R7 lane3");
    bus_read(3'd4, 8'h00, "R7 addr4");
    bus_read(3'd7, 8'h00, "R7 addr7");

    // R6 chip disabled while read enable low
    cs_n = 1'b1; rd_n = 1'b0; bus_addr = 3'd0; #5;
    expect_item(2, 0, 32'h0, "R6 oe off cs high");
    expect_item(0, 0, 32'h0, "R6 dout zero");
    fire();
    cs_n = 1'b0; rd_n = 1'b1; #5;
    expect_item(2, 0, 32'h0, "R6 oe off rd high");
    expect_item(0, 0, 32'h0, "R6 dout zero rd high");
    fire();
    cs_n = 1'b1;

    // R8 partial update, staging retained, commit to 3
    wr(3'd1, 8'h55);
    wr(3'd4, 8'h03);
    check_words("R8 word 3 partial");
    expect_item(1, 3, 32'hAABB55DD, "R8 staging retained");
    fire();

    // R4 select only
    wr(3'd0, 8'h11);
    wr(3'd4, 8'h8C);
    check_words("R4 no commit");
    bus_read(3'd1, 8'hCC, "R4 index selects 12");

    // R5 ignored writes
    bus_write(3'd2, 8'hEE, 1'b1, 1'b1, 80);
    bus_write(3'd3, 8'hEE, 1'b0, 1'b0, 80);
    bus_write(3'd4, 8'h05, 1'b1, 1'b1, 80);
    check_words("R5 no commit from ignored index write");
    wr(3'd4, 8'h07);
    check_words("R5 staging untouched");
    expect_item(1, 7, 32'hAABB5511, "R5 word 7");
    fire();

    // R9 out-of-range index
    wr(3'd4, 8'h28);
    check_words("R9 index 40 commits nothing");
    bus_read(3'd0, 8'h00, "R9 index 40 reads zero");
    wr(3'd4, 8'h9E);
    bus_read(3'd2, 8'h00, "R9 unwritten word 30");

    // R10 minimum spacing: commit then staging write four core cycles later
    @(negedge clk);
    wr(3'd0, 8'h42);
    cs_n = 1'b0; rd_n = 1'b1; bus_addr = 3'd4; bus_din = 8'h14;
    #5 wr_strobe = 1'b1;
    #1;
    expect_item(1, 20, 32'h0, "R10 word 20 before sync");
    fire();
    m_words[20] = m_stage;
    #34 wr_strobe = 1'b0;
    #39;
    bus_write(3'd0, 8'h77, 1'b0, 1'b1, 40);
    m_stage[7:0] = 8'h77;
    #200;
    check_words("R10 commit undisturbed");
    expect_item(1, 20, 32'hAABB5542, "R10 word 20 value");
    fire();
    wr(3'd4, 8'h15);
    expect_item(1, 21, 32'hAABB5577, "R10 later commit sees new byte");
    fire();
    check_words("R10 final");

    done = 1;
    finish_run();
  end
endmodule